// File: doc/BRIEF.md
# Dual-Clock Resettable Line Delay Memory

This block holds one scan line of pixel words and plays it back later. It is used as a variable-length line delay in image pipelines. The write side and the read side each have their own clock, active-low enable and active-low reset, and the two sides may run with no fixed phase or frequency relation. Each side keeps a pointer into a shared storage array. A reset strobe on a side sends that side's pointer back to address zero. The spacing between the write reset and the read reset sets how long each word stays in the line, so no full or empty logic is needed.

Words are written on the rising edge of the write clock. The read side fetches into an output register on the rising edge of the read clock. An active-low output enable gates the registered word onto the data output. The pad's high-impedance state appears as a separate drive flag, and the data bus is forced to zero whenever the drive flag is low.

Top module: `line_delay_mem`

## Requirements
- R1: The array holds DEPTH words of WIDTH bits (defaults 2048 and 10; full-length lines use DEPTH = 8192). Words read out after a read reset match, in order, the words stored after the matching write reset.
- R2: A write clock edge with `wrst_n` low stores nothing and moves the write pointer to address 0. The next accepted word goes to address 0, and the words after it go to 1, 2, and so on.
- R3: A write clock edge with `wrst_n` high and `we_n` high stores nothing and leaves the write pointer unchanged.
- R4: A read clock edge with `rrst_n` low moves the read pointer to address 0 and leaves the output register unchanged. The next fetch returns the word at address 0.
- R5: A read clock edge with `rrst_n` high and `re_n` high leaves both the read pointer and the output register unchanged.
- R6: Each pointer steps from DEPTH-1 back to 0 when no reset arrives before the end of the array.
- R7: A fetch loads the word at the current read pointer into the output register on that read clock edge, and the pointer then advances by one.
- R8: With `oe_n` high, `q_drive` is 0 and `q_data` is all zeros. With `oe_n` low, `q_drive` is 1 and `q_data` shows the output register. Both follow `oe_n` without a clock.
- R9: A reset overrides a low enable on the same edge. Nothing is stored, or nothing is fetched, and the pointer goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write pointer reset, active low, sampled on wclk |
| we_n | input | 1 | Write enable, active low, sampled on wclk |
| din | input | WIDTH | Word to be stored |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read pointer reset, active low, sampled on rclk |
| re_n | input | 1 | Read enable, active low, sampled on rclk |
| oe_n | input | 1 | Output enable, active low, combinational |
| q_data | output | WIDTH | Registered read word, zero when not driven |
| q_drive | output | 1 | High when the data output would be driven |

## Verification
A stored word becomes visible only through a later fetch. The fetched word is in `q_data` right after the read clock edge that samples `re_n` low. The bench's monitor wakes on each read rising edge, records the strobes the driver set up half a cycle earlier, and compares the outputs two nanoseconds later. On edges with no fetch, including reset edges, the monitor expects the previous word to persist. Output-enable changes are combinational, so they are checked in the same sampling window as the edge that follows them.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  typedef enum logic [1:0] {
    PORT_REWIND = 2'd0,
    PORT_STEP   = 2'd1,
    PORT_HOLD   = 2'd2
  } port_act_e;

  // Reset wins over enable; both are active low.
  function automatic port_act_e port_decode(input logic rst_n, input logic en_n);
    if (!rst_n)      return PORT_REWIND;
    else if (!en_n)  return PORT_STEP;
    else             return PORT_HOLD;
  endfunction

  // Next address with wrap at the array end.
  function automatic logic [31:0] ptr_step(input logic [31:0] cur, input logic [31:0] depth);
    return (cur == depth - 32'd1) ? 32'd0 : cur + 32'd1;
  endfunction

endpackage

// File: rtl/ldm_port_ptr.sv
module ldm_port_ptr #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  output logic [AW-1:0] ptr,
  output logic          step
);
  import ldm_pkg::*;

  port_act_e act;

  always_comb begin
    act  = port_decode(rst_n, en_n);
    step = (act == PORT_STEP);
  end

  always_ff @(posedge clk) begin
    case (act)
      PORT_REWIND: ptr <= '0;
      PORT_STEP:   ptr <= AW'(ptr_step(32'(ptr), 32'(DEPTH)));
      default:     ptr <= ptr;
    endcase
  end

endmodule

// File: rtl/ldm_dpram.sv
module ldm_dpram #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic             wclk,
  input  logic             wen,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             ren,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) mem[waddr] <= wdata;
  end

  // Output register doubles as the read port's data register.
  always_ff @(posedge rclk) begin
    if (ren) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ldm_out_gate.sv
module ldm_out_gate #(
  parameter int WIDTH = 10
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] q_data,
  output logic             q_drive
);
  always_comb begin
    q_drive = ~oe_n;
    q_data  = q_drive ? word : '0;
  end
endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 2048
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             we_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             re_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] q_data,
  output logic             q_drive
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Named internal events, visible to the bound checker.
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             wr_store;
  logic             rd_fetch;
  logic [WIDTH-1:0] rd_word;

  ldm_port_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ptr (
    .clk   (wclk),
    .rst_n (wrst_n),
    .en_n  (we_n),
    .ptr   (wr_ptr),
    .step  (wr_store)
  );

  ldm_port_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ptr (
    .clk   (rclk),
    .rst_n (rrst_n),
    .en_n  (re_n),
    .ptr   (rd_ptr),
    .step  (rd_fetch)
  );

  ldm_dpram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .wclk  (wclk),
    .wen   (wr_store),
    .waddr (wr_ptr),
    .wdata (din),
    .rclk  (rclk),
    .ren   (rd_fetch),
    .raddr (rd_ptr),
    .rdata (rd_word)
  );

  ldm_out_gate #(.WIDTH(WIDTH)) u_gate (
    .oe_n    (oe_n),
    .word    (rd_word),
    .q_data  (q_data),
    .q_drive (q_drive)
  );

endmodule

// File: rtl/line_delay_mem_chk.sv
module line_delay_mem_chk #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 2048
) (
  input logic                                   wclk,
  input logic                                   wrst_n,
  input logic                                   we_n,
  input logic                                   rclk,
  input logic                                   rrst_n,
  input logic                                   re_n,
  input logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wr_ptr,
  input logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_ptr,
  input logic [WIDTH-1:0]                       rd_word
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // Two-state flags start at zero: pointers are only defined after a port reset.
  bit w_armed;
  bit r_armed;
  bit r_loaded;

  always_ff @(posedge wclk) if (!wrst_n) w_armed <= 1'b1;
  always_ff @(posedge rclk) if (!rrst_n) r_armed <= 1'b1;
  always_ff @(posedge rclk) if (rrst_n && !re_n) r_loaded <= 1'b1;

  p_wr_rewind_r2: assert property (@(posedge wclk) disable iff (!w_armed)
    !wrst_n |=> (wr_ptr == '0));

  p_wr_freeze_r3: assert property (@(posedge wclk) disable iff (!w_armed)
    (wrst_n && we_n) |=> $stable(wr_ptr));

  p_wr_step_r6: assert property (@(posedge wclk) disable iff (!w_armed)
    (wrst_n && !we_n) |=>
      (($past(wr_ptr) == LAST) ? (wr_ptr == '0) : (wr_ptr == $past(wr_ptr) + 1'b1)));

  p_rd_rewind_r4: assert property (@(posedge rclk) disable iff (!r_armed)
    !rrst_n |=> (rd_ptr == '0));

  p_rd_rewind_keep_r4: assert property (@(posedge rclk) disable iff (!r_loaded)
    !rrst_n |=> $stable(rd_word));

  p_rd_freeze_r5: assert property (@(posedge rclk) disable iff (!r_armed)
    (rrst_n && re_n) |=> $stable(rd_ptr));

  p_rd_hold_word_r5: assert property (@(posedge rclk) disable iff (!r_loaded)
    (rrst_n && re_n) |=> $stable(rd_word));

  p_rd_step_r7: assert property (@(posedge rclk) disable iff (!r_armed)
    (rrst_n && !re_n) |=>
      (($past(rd_ptr) == LAST) ? (rd_ptr == '0) : (rd_ptr == $past(rd_ptr) + 1'b1)));

endmodule

bind line_delay_mem line_delay_mem_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .wclk    (wclk),
  .wrst_n  (wrst_n),
  .we_n    (we_n),
  .rclk    (rclk),
  .rrst_n  (rrst_n),
  .re_n    (re_n),
  .wr_ptr  (wr_ptr),
  .rd_ptr  (rd_ptr),
  .rd_word (rd_word)
);

// File: tb/test_line_delay_mem.sv
`timescale 1ns/1ps
module test_line_delay_mem;
  localparam int W = 10;
  localparam int D = 16;

  logic         wclk = 1'b0, rclk = 1'b0;
  logic         wrst_n = 1'b1, we_n = 1'b1, rrst_n = 1'b1, re_n = 1'b1, oe_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q_data;
  logic         q_drive;

  line_delay_mem #(.WIDTH(W), .DEPTH(D)) i_line_delay_mem (
    .wclk(wclk), .wrst_n(wrst_n), .we_n(we_n), .din(din),
    .rclk(rclk), .rrst_n(rrst_n), .re_n(re_n), .oe_n(oe_n),
    .q_data(q_data), .q_drive(q_drive)
  );

  always #10 wclk = ~wclk;   // 50 MHz write side
  always #13 rclk = ~rclk;   // unrelated read side

  int unsigned  n_checks = 0, n_fails = 0;
  logic [W-1:0] model [D];
  int           wp = 0, rp = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] last_word = '0;
  bit           have_last = 1'b0;
  bit           done = 1'b0;

  function automatic logic [W-1:0] pat(input int i);
    return W'(i * 97 + 693);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---- write driver ----
  task automatic wr_word(input logic [W-1:0] v);
    @(negedge wclk); wrst_n = 1'b1; we_n = 1'b0; din = v;
    model[wp] = v; wp = (wp + 1) % D;
  endtask
  task automatic wr_idle();
    @(negedge wclk); wrst_n = 1'b1; we_n = 1'b1; din = ~din;   // junk, must not land (R3)
  endtask
  task automatic wr_reset(input bit en_low);
    @(negedge wclk); wrst_n = 1'b0; we_n = en_low ? 1'b0 : 1'b1; din = W'(10'h3FF); // R2 / R9
    wp = 0;
  endtask

  // ---- read driver: pushes expectations ----
  task automatic rd_word(input string req);
    @(negedge rclk); rrst_n = 1'b1; re_n = 1'b0;
    exp_q.push_back(model[rp]); tag_q.push_back(req);
    rp = (rp + 1) % D;
  endtask
  task automatic rd_idle();
    @(negedge rclk); rrst_n = 1'b1; re_n = 1'b1;
  endtask
  task automatic rd_reset(input bit en_low);
    @(negedge rclk); rrst_n = 1'b0; re_n = en_low ? 1'b0 : 1'b1;
    rp = 0;
  endtask

  // ---- monitor ----
  initial begin
    forever begin
      bit fetch, rew;
      @(posedge rclk);
      fetch = rrst_n && !re_n;
      rew   = !rrst_n;
      #2;
      if (fetch && exp_q.size() > 0) begin
        last_word = exp_q.pop_front();
        have_last = 1'b1;
        if (!oe_n) check(tag_q.pop_front(), q_data, last_word);    // R7 fetch result
        else void'(tag_q.pop_front());
      end else if (have_last && !oe_n) begin
        check(rew ? "R4" : "R5", q_data, last_word);               // output held
      end
      if (oe_n) begin
        check("R8", W'(q_drive), '0);
        check("R8", q_data, '0);
      end else if (have_last) begin
        check("R8", W'(q_drive), W'(1));
      end
    end
  end

  // ---- watchdog ----
  initial begin
    #2_000_000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run hung (all R), got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  // ---- stimulus ----
  initial begin
    wr_reset(1'b0); wr_reset(1'b0); wr_idle();
    rd_reset(1'b0); rd_reset(1'b0); rd_idle();
    #3;
    check("R8", W'(q_drive), '0);   // reset state, output disabled
    check("R8", q_data, '0);

    // R1 / R3: line with disable cycles mixed in
    for (int i = 0; i < 10; i++) begin
      wr_word(pat(i));
      if (i % 3 == 2) wr_idle();
    end
    wr_idle();
    @(negedge rclk); oe_n = 1'b0;
    rd_reset(1'b0);
    for (int i = 0; i < 10; i++) begin
      rd_word(i < 5 ? "R1" : "R7");
      if (i % 4 == 1) rd_idle();
    end
    rd_idle(); rd_idle();

    // R2: write reset mid-line restarts at address 0
    wr_reset(1'b0);
    for (int i = 0; i < 5; i++) wr_word(pat(40 + i));
    wr_reset(1'b0);
    for (int i = 0; i < 3; i++) wr_word(pat(60 + i));
    wr_idle();
    rd_reset(1'b0);
    for (int i = 0; i < 5; i++) rd_word("R2");
    rd_idle();

    // R6: both pointers wrap past DEPTH-1
    wr_reset(1'b0);
    for (int i = 0; i < D + 4; i++) wr_word(pat(100 + i));
    wr_idle();
    rd_reset(1'b0);
    for (int i = 0; i < D + 4; i++) rd_word("R6");
    rd_idle();

    // R9: reset beats a low enable on both sides
    wr_reset(1'b1);
    wr_word(pat(200));
    wr_idle();
    rd_reset(1'b0);
    rd_word("R9"); rd_word("R9");
    rd_reset(1'b1);                  // output must hold (R4)
    for (int i = 0; i < 5; i++) rd_word("R9");
    rd_idle();

    // R8: output enable toggling
    @(negedge rclk); oe_n = 1'b1;
    rd_idle(); rd_idle(); rd_idle();
    @(negedge rclk); oe_n = 1'b0;
    rd_idle(); rd_idle();

    repeat (4) @(negedge rclk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule